// File: doc/BRIEF.md
# Channel-Parallel 3x3 Depthwise Convolution Engine

This block filters a raster-ordered feature-map stream with a separate 3x3 kernel for each channel. Each input beat carries one pixel position for `N_IO` channels at once. All lanes share one kernel-tap schedule, and each lane applies its own weights. The two rows above the current one are kept on chip, so every input pixel is read exactly once. Positions outside the image are treated as zero ("same" padding), so the output image has the same size as the input image.

The datapath has one multiplier per lane. It does not apply all nine kernel taps in parallel. It steps through taps 0 to 8 at one tap per clock. For each tap it presents the index on `wt_tap_o`, and the surrounding logic returns that tap's weights for all lanes on `wt_i`. The weights are captured into a buffer register and used in the following cycle. The caller selects which channel group's weights the tap index addresses, so a wide channel count is handled as a series of frames, one per group of `N_IO` channels. After the last pixel of a frame, the block flushes the right column and bottom row internally. It is then ready for the next frame.

Top module: `dwconv3x3_seq`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high, so the first pixel of a frame can be accepted at once.
- R2: For each output position (y,x) and lane, the result equals the sum over kernel row a and column b (0..2) of pixel(y+a-1, x+b-1) times weight[3a+b]. Pixels outside the image count as zero. Data and weights are signed two's complement, and the sum keeps full precision in `OW` bits.
- R3: Each frame of `IMG_W*IMG_H` accepted pixels yields exactly `IMG_W*IMG_H` results, in raster order (row by row, left to right).
- R4: During a computation, `wt_tap_o` walks 0,1,...,8 in consecutive cycles. Tap k is row-major (top-left k=0, bottom-right k=8). The weight for tap k is sampled from `wt_i` at the clock edge that ends the cycle in which `wt_tap_o` equals k.
- R5: `out_valid` is a single-cycle pulse and is never high in two consecutive cycles.
- R6: `in_ready` is low for the 10 cycles of each computation. A beat offered while `in_ready` is low, or with `in_valid` low, is not consumed, and the result does not depend on such stalls.
- R7: Lanes are independent. Lane i takes data bits [i*DW +: DW], weight bits [i*WW +: WW], and drives result bits [i*OW +: OW].
- R8: Frames may follow each other with no gap. No pixel of an earlier frame leaks into the padding of the next frame.
- R9: The extreme case of every pixel and every weight at the most negative value produces 9*2^(DW+WW-2) at interior positions without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel beat is valid |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_data | input | N_IO*DW | Packed signed pixels, lane 0 in the low bits |
| wt_tap_o | output | 4 | Kernel tap whose weights are requested |
| wt_i | input | N_IO*WW | Packed signed weights for the requested tap |
| out_valid | output | 1 | Result beat valid (one cycle) |
| out_data | output | N_IO*OW | Packed signed results, lane 0 in the low bits |

## Verification
The weight fetch for tap k+1 happens in the same cycle as the multiply-accumulate for tap k. A one-cycle skew between the tap index and the buffered weight therefore pairs each pixel with its neighbour's weight. This is provoked with an impulse image and nine distinct weights: every output position then exposes exactly one weight, so a misplaced or reordered tap shows up as a wrong value at a known position. Random frames with and without input stalls, a most-negative saturation frame and a lane-isolation frame are compared against a reference convolution computed in the bench. Each frame's result count is also checked.

// File: rtl/dw_pkg.sv
package dw_pkg;
  typedef enum logic {ST_FETCH, ST_TAP} dw_state_e;
  localparam int unsigned TAPS     = 9;
  localparam int unsigned LAST_PH  = TAPS;  // phase in which the result is formed
endpackage

// File: rtl/dw_linebuf.sv
// Two-row history. Supplies the upper two pixels of the incoming column,
// masked to zero where they fall above the image or beyond its right edge.
module dw_linebuf #(
  parameter int unsigned N_IO  = 2,
  parameter int unsigned DW    = 8,
  parameter int unsigned IMG_W = 8,
  localparam int unsigned PW   = N_IO * DW,
  localparam int unsigned CW   = $clog2(IMG_W + 1)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [CW-1:0] col,
  input  logic          col_ok,
  input  logic          row_ge1,
  input  logic          row_ge2,
  input  logic [PW-1:0] pix_in,
  output logic [PW-1:0] px_up2,
  output logic [PW-1:0] px_up1
);
  logic [PW-1:0] row_a [IMG_W];  // row r-1
  logic [PW-1:0] row_b [IMG_W];  // row r-2
  logic [CW-1:0] idx;

  always_comb begin
    idx    = col_ok ? col : '0;
    px_up1 = (col_ok && row_ge1) ? row_a[idx] : '0;
    px_up2 = (col_ok && row_ge2) ? row_b[idx] : '0;
  end

  // read-before-write on the same column: old row_a moves down one row
  always_ff @(posedge clk) begin
    if (we && col_ok) begin
      row_b[idx] <= row_a[idx];
      row_a[idx] <= pix_in;
    end
  end
endmodule

// File: rtl/dw_window.sv
// 3x3 window of packed lane pixels, flat row-major (k = 3*row + col).
module dw_window #(
  parameter int unsigned N_IO = 2,
  parameter int unsigned DW   = 8,
  localparam int unsigned PW  = N_IO * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic          first_col,
  input  logic [PW-1:0] new_top,
  input  logic [PW-1:0] new_mid,
  input  logic [PW-1:0] new_bot,
  input  logic [3:0]    tap_sel,
  output logic [PW-1:0] tap_px
);
  logic [PW-1:0] win   [9];
  logic [PW-1:0] win_n [9];
  logic [PW-1:0] newc  [3];

  always_comb begin
    newc[0] = new_top;
    newc[1] = new_mid;
    newc[2] = new_bot;
    for (int r = 0; r < 3; r++) begin
      win_n[3*r]   = first_col ? '0 : win[3*r+1];
      win_n[3*r+1] = first_col ? '0 : win[3*r+2];
      win_n[3*r+2] = newc[r];
    end
    tap_px = (tap_sel < 4'd9) ? win[tap_sel] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 9; k++) win[k] <= '0;
    end else if (shift) begin
      for (int k = 0; k < 9; k++) win[k] <= win_n[k];
    end
  end
endmodule

// File: rtl/dw_mac_lane.sv
// One lane: signed multiply and accumulate over the tap walk.
module dw_mac_lane #(
  parameter int unsigned DW = 8,
  parameter int unsigned WW = 8,
  parameter int unsigned OW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          first,
  input  logic [DW-1:0] px,
  input  logic [WW-1:0] wt,
  output logic [OW-1:0] sum_o
);
  logic signed [DW+WW-1:0] prod;
  logic signed [OW-1:0]    acc;

  always_comb begin
    prod  = $signed(px) * $signed(wt);
    sum_o = (first ? '0 : acc) + OW'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= sum_o;
  end
endmodule

// File: rtl/dwconv3x3_seq.sv
module dwconv3x3_seq #(
  parameter int unsigned N_IO  = 2,
  parameter int unsigned DW    = 8,
  parameter int unsigned WW    = 8,
  parameter int unsigned IMG_W = 8,
  parameter int unsigned IMG_H = 6,
  localparam int unsigned OW   = DW + WW + 4,
  localparam int unsigned PW   = N_IO * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PW-1:0]      in_data,
  output logic [3:0]         wt_tap_o,
  input  logic [N_IO*WW-1:0] wt_i,
  output logic               out_valid,
  output logic [N_IO*OW-1:0] out_data
);
  import dw_pkg::*;
  localparam int unsigned CW = $clog2(IMG_W + 1);
  localparam int unsigned RW = $clog2(IMG_H + 1);

  dw_state_e    state, state_n;
  logic [3:0]   phase, phase_n;
  logic [CW-1:0] col, col_n;
  logic [RW-1:0] row, row_n;
  logic          real_pos, step, emit_due, col_ok;
  logic [PW-1:0] pix_in, px_up1, px_up2, tap_px;
  logic [N_IO*WW-1:0] wt_buf;
  logic [N_IO*OW-1:0] sum_all;
  logic          mac_en, mac_first, wt_load, fin;
  logic [3:0]    win_tap;

  // ---------------- sequencer: next state ----------------
  always_comb begin
    col_ok   = col < CW'(IMG_W);
    real_pos = col_ok && (row < RW'(IMG_H));
    step     = (state == ST_FETCH) && (!real_pos || in_valid);
    emit_due = (row != '0) && (col != '0);
    in_ready = (state == ST_FETCH) && real_pos;
    pix_in   = real_pos ? in_data : '0;
    fin      = (state == ST_TAP) && (phase == 4'(LAST_PH));
    state_n  = state;
    phase_n  = phase;
    col_n    = col;
    row_n    = row;
    if (step) begin
      if (col == CW'(IMG_W)) begin
        col_n = '0;
        row_n = (row == RW'(IMG_H)) ? '0 : row + 1'b1;
      end else begin
        col_n = col + 1'b1;
      end
      if (emit_due) begin
        state_n = ST_TAP;
        phase_n = '0;
      end
    end else if (state == ST_TAP) begin
      phase_n = phase + 4'd1;
      if (fin) begin
        state_n = ST_FETCH;
        phase_n = '0;
      end
    end
  end

  // ---------------- sequencer: registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      phase <= '0;
      col   <= '0;
      row   <= '0;
    end else begin
      state <= state_n;
      phase <= phase_n;
      col   <= col_n;
      row   <= row_n;
    end
  end

  // ---------------- storage ----------------
  dw_linebuf #(.N_IO(N_IO), .DW(DW), .IMG_W(IMG_W)) u_lb (
    .clk(clk), .we(step), .col(col), .col_ok(col_ok),
    .row_ge1(row >= RW'(1)), .row_ge2(row >= RW'(2)),
    .pix_in(pix_in), .px_up2(px_up2), .px_up1(px_up1)
  );

  always_comb begin
    wt_load   = (state == ST_TAP) && (phase < 4'(TAPS));
    mac_en    = (state == ST_TAP) && (phase != '0);
    mac_first = (phase == 4'd1);
    win_tap   = mac_en ? phase - 4'd1 : 4'd0;
    wt_tap_o  = phase;
  end

  dw_window #(.N_IO(N_IO), .DW(DW)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(step), .first_col(col == '0),
    .new_top(px_up2), .new_mid(px_up1), .new_bot(pix_in),
    .tap_sel(win_tap), .tap_px(tap_px)
  );

  // weight buffer: captured one cycle ahead of its use
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wt_buf <= '0;
    else if (wt_load) wt_buf <= wt_i;
  end

  // ---------------- lanes ----------------
  for (genvar g = 0; g < N_IO; g++) begin : g_lane
    dw_mac_lane #(.DW(DW), .WW(WW), .OW(OW)) u_mac (
      .clk(clk), .rst_n(rst_n), .en(mac_en), .first(mac_first),
      .px(tap_px[g*DW +: DW]), .wt(wt_buf[g*WW +: WW]),
      .sum_o(sum_all[g*OW +: OW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fin;
      if (fin) out_data <= sum_all;
    end
  end

  // ---------------- assertions ----------------
  a_r4_tap_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAP && phase < 4'd8) |=> (wt_tap_o == $past(wt_tap_o) + 4'd1));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAP) |-> !in_ready);
  a_r3_emit_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(state) == ST_TAP && $past(wt_tap_o) == 4'(LAST_PH)));
  a_r6_no_step_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAP) |=> $stable(col) && $stable(row));
endmodule

// File: tb/tb_dwconv3x3_seq.sv
module tb_dwconv3x3_seq;
  localparam int N_IO = 2, DW = 8, WW = 8, W = 8, H = 6;
  localparam int OW = DW + WW + 4;

  logic clk = 1'b0, rst_n;
  logic in_valid, in_ready;
  logic [N_IO*DW-1:0] in_data;
  logic [3:0] wt_tap_o;
  logic [N_IO*WW-1:0] wt_i;
  logic out_valid;
  logic [N_IO*OW-1:0] out_data;

  dwconv3x3_seq #(.N_IO(N_IO), .DW(DW), .WW(WW), .IMG_W(W), .IMG_H(H)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wt_tap_o(wt_tap_o), .wt_i(wt_i),
    .out_valid(out_valid), .out_data(out_data));

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, bad = 0, frame_cnt = 0;
  logic signed [DW-1:0] img [H][W][N_IO];
  logic signed [WW-1:0] wts [9][N_IO];
  logic [N_IO*OW-1:0] exp_q[$];
  string tag;

  always_comb begin
    for (int i = 0; i < N_IO; i++)
      wt_i[i*WW +: WW] = (wt_tap_o < 4'd9) ? wts[wt_tap_o][i] : '0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      frame_cnt++;
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected result act=%0h exp=none", out_data);
      end else begin
        logic [N_IO*OW-1:0] e;
        e = exp_q.pop_front();
        if (e !== out_data) begin
          bad++;
          $display("FAIL R2 R4 %s act=%0h exp=%0h", tag, out_data, e);
        end
      end
    end
  end

  function automatic logic [N_IO*OW-1:0] ref_px(int y, int x);
    logic [N_IO*OW-1:0] v;
    for (int ch = 0; ch < N_IO; ch++) begin
      longint s = 0;
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++) begin
          int yy = y + a - 1, xx = x + b - 1;
          if (yy >= 0 && yy < H && xx >= 0 && xx < W)
            s += longint'(img[yy][xx][ch]) * longint'(wts[3*a+b][ch]);
        end
      v[ch*OW +: OW] = OW'(s);
    end
    return v;
  endfunction

  task automatic send(input logic [N_IO*DW-1:0] px, output int waited);
    waited = 0;
    in_data = px;
    in_valid = 1'b1;
    while (!in_ready) begin
      waited++;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_frame(input string name, input int gaps, input bit chk_wait);
    int wt_cnt;
    tag = name;
    frame_cnt = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) exp_q.push_back(ref_px(y, x));
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        logic [N_IO*DW-1:0] p;
        for (int ch = 0; ch < N_IO; ch++) p[ch*DW +: DW] = img[y][x][ch];
        send(p, wt_cnt);
        // R6: pixel (1,2) offered right after (1,1) waits out one full walk
        if (chk_wait && y == 1 && x == 2) chk(wt_cnt == 10, "R6 stall length", wt_cnt, 10);
        if (gaps != 0) repeat ($urandom_range(gaps)) @(negedge clk);
      end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(frame_cnt == W*H, "R3 results per frame", frame_cnt, W*H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    in_valid = 1'b0;
    in_data = '0;
    for (int k = 0; k < 9; k++) for (int c = 0; c < N_IO; c++) wts[k][c] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // random frame, back to back input (R2)
    for (int k = 0; k < 9; k++) for (int c = 0; c < N_IO; c++) wts[k][c] = DW'($urandom);
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) for (int c = 0; c < N_IO; c++)
      img[y][x][c] = DW'($urandom);
    run_frame("random", 0, 1'b1);

    // impulse with distinct weights exposes tap order (R4), next frame with no gap (R8)
    for (int k = 0; k < 9; k++) for (int c = 0; c < N_IO; c++) wts[k][c] = WW'(k + 1 + 16*c);
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) for (int c = 0; c < N_IO; c++)
      img[y][x][c] = (y == 2 && x == 3) ? 8'sd1 : 8'sd0;
    run_frame("R4 impulse", 0, 1'b0);

    // most negative everywhere (R9)
    for (int k = 0; k < 9; k++) for (int c = 0; c < N_IO; c++) wts[k][c] = 8'sh80;
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) for (int c = 0; c < N_IO; c++)
      img[y][x][c] = 8'sh80;
    run_frame("R9 extreme", 0, 1'b0);
    chk(ref_px(2, 2)[OW-1:0] == OW'(147456), "R9 reference interior", ref_px(2, 2)[OW-1:0], 147456);

    // lane isolation with random input stalls (R7, R6)
    for (int k = 0; k < 9; k++) begin
      wts[k][0] = WW'($urandom);
      wts[k][1] = WW'($urandom);
    end
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) begin
      img[y][x][0] = DW'($urandom);
      img[y][x][1] = '0;
    end
    run_frame("R7 R6 isolated stalled", 4, 1'b0);

    // stale data must not leak into the next frame's padding (R8)
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) for (int c = 0; c < N_IO; c++)
      img[y][x][c] = DW'($urandom);
    run_frame("R8 follow-up", 2, 1'b0);

    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready for next frame", in_ready, 1);
    chk(out_valid == 1'b0, "R5 idle after frames", out_valid, 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule